// File: doc/BRIEF.md
# Pipelined Fraction Divider

This block divides an unsigned numerator by an unsigned denominator of the same width when the numerator is no larger than the denominator. The result is a fixed-point fraction with `FRAC` bits after the binary point and one integer bit. The divider uses restoring shift-and-subtract steps and produces one quotient bit per pipeline stage, most significant bit first. It contains no divide operator.

A new operand pair can be presented on every clock, and every pair yields exactly one result after a fixed delay. An opaque tag travels with each pair so that a downstream consumer can match results to their requests. Two cases are handled specially. An equal numerator and denominator yields exactly 1.0. A zero denominator yields 0 and raises a flag that accompanies that result.

Top module: `frac_div_pipe`

## Requirements
- R1: For 0 ≤ num < den, out_quot equals floor(num · 2^FRAC / den). Bit FRAC of out_quot is the integer bit and bits FRAC-1..0 are the fraction.
- R2: When num == den and den ≠ 0, out_quot equals exactly 2^FRAC (integer bit set, fraction bits zero).
- R3: When den == 0, out_quot is 0 and out_div_zero is 1 in the same cycle as that result. For any nonzero den, out_div_zero is 0.
- R4: A pair accepted with in_valid high on a rising edge appears with out_valid high exactly FRAC+3 rising edges later, counting the accepting edge.
- R5: Operand pairs presented on consecutive cycles produce results on consecutive cycles, with no stall and no loss.
- R6: out_tag equals the in_tag that was presented with the pair whose result is shown.
- R7: While rst_n is low, and until the first accepted pair has travelled through the pipeline, out_valid, out_div_zero and out_quot are all 0.
- R8: A cycle with in_valid low produces, FRAC+3 cycles later, out_valid low and out_div_zero low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| in_num | input | W | Unsigned numerator, no larger than in_den |
| in_den | input | W | Unsigned denominator |
| in_tag | input | TAG_W | User tag carried with the pair |
| out_valid | output | 1 | Result present this cycle |
| out_quot | output | FRAC+1 | Quotient: one integer bit above FRAC fraction bits |
| out_tag | output | TAG_W | Tag of the pair whose result is shown |
| out_div_zero | output | 1 | Result came from a zero denominator |

## Verification
The bench uses a narrow configuration (6-bit operands, 6 fraction bits). The first run streams every numerator/denominator pair with num ≤ den back to back. This covers the ordinary quotients, the exact 1.0 case on the diagonal, and the zero-denominator row, and it shows that the stages do not interfere when full. A second run inserts an idle cycle between pairs, so a result that leaks into a bubble slot, or a valid bit that moves by one stage, shows up as a mismatch in valid or tag. A rotating tag on each pair separates a wrong quotient from a right quotient delivered in the wrong slot.

// File: rtl/frac_div_pipe.sv
module frac_div_pipe #(
  parameter int W     = 16,
  parameter int FRAC  = 16,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [W-1:0]     in_num,
  input  logic [W-1:0]     in_den,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  output logic [FRAC:0]    out_quot,
  output logic [TAG_W-1:0] out_tag,
  output logic             out_div_zero
);

  localparam logic [FRAC:0] ONE = (FRAC+1)'(1) << FRAC;

  logic             v_i;
  logic [W-1:0]     num_i, den_i;
  logic [TAG_W-1:0] tag_i;

  logic             v_s   [FRAC+1];
  logic             eq_s  [FRAC+1];
  logic             dz_s  [FRAC+1];
  logic [TAG_W-1:0] tag_s [FRAC+1];
  logic [FRAC-1:0]  q_s   [FRAC+1];
  logic [W:0]       rem_s [FRAC];
  logic [W-1:0]     den_s [FRAC];

  logic [FRAC-1:0]  ge;
  logic [W:0]       rnext [FRAC];

  for (genvar i = 0; i < FRAC; i++) begin : g_step
    wire [W+1:0] dbl = {rem_s[i], 1'b0};
    assign ge[i] = dbl >= {2'b0, den_s[i]};
    if (i < FRAC-1) begin : g_rem
      wire [W:0] dif = dbl[W:0] - {1'b0, den_s[i]};
      assign rnext[i] = ge[i] ? dif : dbl[W:0];
    end else begin : g_last
      assign rnext[i] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_i   <= 1'b0;
      num_i <= '0;
      den_i <= '0;
      tag_i <= '0;
      for (int i = 0; i <= FRAC; i++) begin
        v_s[i]   <= 1'b0;
        eq_s[i]  <= 1'b0;
        dz_s[i]  <= 1'b0;
        tag_s[i] <= '0;
        q_s[i]   <= '0;
      end
      for (int i = 0; i < FRAC; i++) begin
        rem_s[i] <= '0;
        den_s[i] <= '0;
      end
      out_valid    <= 1'b0;
      out_quot     <= '0;
      out_tag      <= '0;
      out_div_zero <= 1'b0;
    end else begin
      v_i   <= in_valid;
      num_i <= in_num;
      den_i <= in_den;
      tag_i <= in_tag;

      v_s[0]   <= v_i;
      eq_s[0]  <= (num_i == den_i) && (den_i != '0);
      dz_s[0]  <= (den_i == '0);
      tag_s[0] <= tag_i;
      q_s[0]   <= '0;
      rem_s[0] <= {1'b0, num_i};
      den_s[0] <= den_i;

      for (int i = 0; i < FRAC; i++) begin
        v_s[i+1]   <= v_s[i];
        eq_s[i+1]  <= eq_s[i];
        dz_s[i+1]  <= dz_s[i];
        tag_s[i+1] <= tag_s[i];
        q_s[i+1]   <= q_s[i] | ({{(FRAC-1){1'b0}}, ge[i]} << (FRAC-1-i));
        if (i < FRAC-1) begin
          rem_s[i+1] <= rnext[i];
          den_s[i+1] <= den_s[i];
        end
      end

      out_valid    <= v_s[FRAC];
      out_tag      <= tag_s[FRAC];
      out_div_zero <= v_s[FRAC] && dz_s[FRAC];
      if (!v_s[FRAC] || dz_s[FRAC]) out_quot <= '0;
      else if (eq_s[FRAC])          out_quot <= ONE;
      else                          out_quot <= {1'b0, q_s[FRAC]};
    end
  end

endmodule

// File: rtl/frac_div_pipe_chk.sv
module frac_div_pipe_chk #(
  parameter int W    = 16,
  parameter int FRAC = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [W-1:0]  in_den,
  input logic          out_valid,
  input logic [FRAC:0] out_quot,
  input logic          out_div_zero
);
  localparam int LAT = FRAC + 3;

  logic [LAT-1:0] vsh, zsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsh <= '0;
      zsh <= '0;
    end else begin
      vsh <= {vsh[LAT-2:0], in_valid};
      zsh <= {zsh[LAT-2:0], in_valid && (in_den == '0)};
    end
  end

  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vsh[LAT-1]);

  a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_div_zero == zsh[LAT-1]);

  a_r3_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_div_zero |-> (out_valid && out_quot == '0));

  a_r2_one_exact: assert property (@(posedge clk) disable iff (!rst_n)
    out_quot[FRAC] |-> (out_quot[FRAC-1:0] == '0));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_quot == '0 && !out_div_zero));
endmodule

bind frac_div_pipe frac_div_pipe_chk #(.W(W), .FRAC(FRAC)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_den(in_den),
  .out_valid(out_valid), .out_quot(out_quot), .out_div_zero(out_div_zero)
);

// File: tb/sim_frac_div_pipe.sv
module sim_frac_div_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int W     = 6;
  localparam int FRAC  = 6;
  localparam int TAG_W = 4;
  localparam int LAT   = FRAC + 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [W-1:0]     in_num = '0, in_den = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic             out_valid;
  logic [FRAC:0]    out_quot;
  logic [TAG_W-1:0] out_tag;
  logic             out_div_zero;

  frac_div_pipe #(.W(W), .FRAC(FRAC), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_num(in_num),
    .in_den(in_den), .in_tag(in_tag), .out_valid(out_valid),
    .out_quot(out_quot), .out_tag(out_tag), .out_div_zero(out_div_zero)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, edges = 0;
  bit done = 0;
  bit    e_v   [32];
  int    e_q   [32];
  bit    e_dz  [32];
  int    e_tag [32];
  string e_req [32];

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %0h expected %0h (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  task automatic step(input bit v, input int n, input int d);
    int s;
    s = (cyc - LAT) % 32;
    if (cyc >= LAT && e_v[s]) begin
      chk(out_valid == 1'b1, "R4 R5 valid", int'(out_valid), 1);
      chk(int'(out_quot) == e_q[s], e_req[s], int'(out_quot), e_q[s]);
      chk(out_div_zero == e_dz[s], "R3 flag", int'(out_div_zero), int'(e_dz[s]));
      chk(int'(out_tag) == e_tag[s], "R6 tag", int'(out_tag), e_tag[s]);
    end else begin
      chk(out_valid == 1'b0, "R8 valid", int'(out_valid), 0);
      chk(out_div_zero == 1'b0, "R8 flag", int'(out_div_zero), 0);
    end
    s = cyc % 32;
    e_v[s]   = v;
    e_tag[s] = cyc % 16;
    e_dz[s]  = v && (d == 0);
    if (d == 0)      begin e_q[s] = 0;                  e_req[s] = "R3 quotient"; end
    else if (n == d) begin e_q[s] = 1 << FRAC;          e_req[s] = "R2 quotient"; end
    else             begin e_q[s] = (n << FRAC) / d;    e_req[s] = "R1 quotient"; end
    in_valid = v;
    in_num   = W'(n);
    in_den   = W'(d);
    in_tag   = TAG_W'(cyc % 16);
    cyc++;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    edges++;
    if (edges > 150000 && !done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) e_v[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 valid", int'(out_valid), 0);
    chk(out_quot == '0, "R7 quotient", int'(out_quot), 0);
    chk(out_div_zero == 1'b0, "R7 flag", int'(out_div_zero), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < (1 << W); d++)
      for (int n = 0; n <= d; n++)
        step(1'b1, n, d);
    for (int d = 0; d < 16; d++)
      for (int n = 0; n <= d; n++) begin
        step(1'b1, n, d);
        step(1'b0, d, n);
      end
    for (int k = 0; k < LAT + 2; k++) step(1'b0, 0, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule